// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers a small set of level-sensitive interrupt request lines from PCI-side devices and combines them into a single cascade request toward a host interrupt controller. Each request line passes through a two-flop synchroniser. The synchronised level then shows up directly in a 32-bit status word. Sources are numbered from the most significant bit downward, so source 0 occupies bit 31.

A 32-bit mask word sits next to the status word. A mask bit set to 1 blocks the source in the same bit position, and a mask bit cleared to 0 lets it through. The cascade output is a level: it stays high for as long as any unmasked source bit is high.

Software reads the status word and keeps the bits whose mask bits are clear. It then services the survivors, scanning from bit 31 downward. An interrupt is cleared at the device that raised it, not in this block.

Top module: `irqagg_cascade`

## Requirements
- R1: Source n (input bit `irq_i[n]`) appears at status bit 31−n. A change on the input reaches the status word and the cascade output on the second rising clock edge after it, and not on the first.
- R2: Status bits 27..0 always read as zero.
- R3: When reset releases, the mask word reads 0xFFF00000, which blocks every source.
- R4: A write to byte offset 0x4 replaces all 32 mask bits, and the mask word reads back exactly what was written. Without such a write, the mask word holds its value.
- R5: `cascade_o` is high exactly when some bit among 31..28 is high in the status word and clear in the mask word. A set mask bit blocks its source.
- R6: Mask bits 19..0 have no effect on `cascade_o`.
- R7: `cascade_o` stays high while an unmasked source stays high, and falls once every unmasked source has dropped. A write to the status offset 0x0 changes neither the status word nor the mask word.
- R8: A read from any offset other than 0x0 (status) or 0x4 (mask) returns zero, and a write there changes no state.
- R9: While reset is asserted, `cascade_o` is low and the status word reads zero, whatever the input levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 4 | Level interrupt request lines; bit n is source n |
| bus_addr_i | input | 4 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| cascade_o | output | 1 | Level cascade request to the host controller |

## Verification
The embedded assertions check several properties on every cycle. After the synchroniser has warmed up, the status level equals the input level from two edges earlier. The mask takes its reset value when reset releases. It loads exactly the written data and holds its value when no write is made. The cascade stays low whenever all four top mask bits are set or no source is high.

Other behaviours need the bench's scenarios to show them:
- the bit-reversed placement of sources in the status word;
- blocking by individual mask bits across several mixed patterns;
- the inertness of the low mask bits;
- writes to the status word and to unmapped offsets being ignored;
- the exact edge on which a new input level becomes visible.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   // Register selected by a bus access
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2
   } irqagg_sel_e;

   // Word holding ones in the top NSRC bits of a WIDTH-bit word
   function automatic logic [63:0] top_field(input int unsigned width,
                                             input int unsigned nsrc);
      logic [63:0] f;
      f = '0;
      for (int unsigned b = 0; b < 64; b++)
         if (b < width && b >= width - nsrc) f[b] = 1'b1;
      return f;
   endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned STAGES  = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] d_i,
   output logic [NUM_SRC-1:0] q_o
);

   initial begin
      assert (STAGES >= 2) else $error("irqagg_sync: STAGES must be at least 2");
      assert (NUM_SRC >= 1) else $error("irqagg_sync: NUM_SRC must be at least 1");
   end

   logic [NUM_SRC-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[0] <= '0;
               else         stage_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) stage_q[s] <= '0;
               else         stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

   // Cycles since reset release, saturating
   logic [1:0] warm_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   generate
      if (STAGES == 2) begin : g_chk2
         assert_sync_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (warm_q >= 2'd2) |-> (q_o == $past(d_i, 2)))
            else $error("R1: synchroniser output does not follow input after two edges");
      end
   endgenerate

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
   import irqagg_pkg::*;
#(
   parameter int unsigned   DATA_W   = 32,
   parameter int unsigned   NUM_SRC  = 4,
   parameter int unsigned   ADDR_W   = 4,
   parameter int unsigned   STAT_OFS = 0,
   parameter int unsigned   MASK_OFS = 4,
   parameter logic [DATA_W-1:0] MASK_RST = 32'hFFF0_0000
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_lvl_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_wr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic [DATA_W-1:0]  status_o,
   output logic [DATA_W-1:0]  mask_o
);

   initial begin
      assert (NUM_SRC <= DATA_W) else $error("irqagg_regs: NUM_SRC exceeds DATA_W");
      assert (STAT_OFS != MASK_OFS) else $error("irqagg_regs: offsets collide");
      assert (MASK_OFS < (1 << ADDR_W) && STAT_OFS < (1 << ADDR_W))
         else $error("irqagg_regs: offset outside address range");
   end

   irqagg_sel_e sel;
   always_comb begin
      if      (bus_addr_i == ADDR_W'(STAT_OFS)) sel = SEL_STAT;
      else if (bus_addr_i == ADDR_W'(MASK_OFS)) sel = SEL_MASK;
      else                                      sel = SEL_NONE;
   end

   // Status: source n lands at bit DATA_W-1-n, other bits tie to zero
   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_stat
         if (b >= DATA_W - NUM_SRC) begin : g_src
            assign status_o[b] = src_lvl_i[DATA_W-1-b];
         end else begin : g_zero
            assign status_o[b] = 1'b0;
         end
      end
   endgenerate

   logic [DATA_W-1:0] mask_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mask_q <= MASK_RST;
      else if (bus_wr_i && sel == SEL_MASK) mask_q <= bus_wdata_i;
   end
   assign mask_o = mask_q;

   always_comb begin
      unique case (sel)
         SEL_STAT: bus_rdata_o = status_o;
         SEL_MASK: bus_rdata_o = mask_q;
         default:  bus_rdata_o = '0;
      endcase
   end

   assert_mask_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (mask_q == MASK_RST))
      else $error("R3: mask not at reset value after reset release");

   assert_mask_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == ADDR_W'(MASK_OFS)) |=> (mask_q == $past(bus_wdata_i)))
      else $error("R4: mask did not load written data");

   assert_mask_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_wr_i && bus_addr_i == ADDR_W'(MASK_OFS)) |=> $stable(mask_q))
      else $error("R4: mask changed without a mask write");

endmodule

// File: rtl/irqagg_cascade.sv
module irqagg_cascade
   import irqagg_pkg::*;
#(
   parameter int unsigned   DATA_W      = 32,
   parameter int unsigned   NUM_SRC     = 4,
   parameter int unsigned   SYNC_STAGES = 2,
   parameter int unsigned   ADDR_W      = 4,
   parameter int unsigned   STAT_OFS    = 0,
   parameter int unsigned   MASK_OFS    = 4,
   parameter logic [DATA_W-1:0] MASK_RST = 32'hFFF0_0000,
   parameter bit            OUT_REG     = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] irq_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_wr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               cascade_o
);

   localparam logic [63:0]       FIELD64   = top_field(DATA_W, NUM_SRC);
   localparam logic [DATA_W-1:0] SRC_FIELD = FIELD64[DATA_W-1:0];

   initial begin
      assert (DATA_W >= 8 && DATA_W <= 64) else $error("irqagg_cascade: DATA_W out of range");
      assert (NUM_SRC >= 1 && NUM_SRC <= DATA_W) else $error("irqagg_cascade: bad NUM_SRC");
   end

   logic [NUM_SRC-1:0] src_lvl;
   logic [DATA_W-1:0]  status_w;
   logic [DATA_W-1:0]  mask_w;
   logic               pend_any;

   irqagg_sync #(
      .NUM_SRC (NUM_SRC),
      .STAGES  (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (irq_i),
      .q_o    (src_lvl)
   );

   irqagg_regs #(
      .DATA_W   (DATA_W),
      .NUM_SRC  (NUM_SRC),
      .ADDR_W   (ADDR_W),
      .STAT_OFS (STAT_OFS),
      .MASK_OFS (MASK_OFS),
      .MASK_RST (MASK_RST)
   ) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_lvl_i   (src_lvl),
      .bus_addr_i  (bus_addr_i),
      .bus_wr_i    (bus_wr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .status_o    (status_w),
      .mask_o      (mask_w)
   );

   assign pend_any = |(status_w & ~mask_w & SRC_FIELD);

   generate
      if (OUT_REG) begin : g_out_reg
         logic casc_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) casc_q <= 1'b0;
            else         casc_q <= pend_any;
         end
         assign cascade_o = casc_q;
      end else begin : g_out_comb
         assign cascade_o = pend_any;
      end
   endgenerate

   generate
      if (!OUT_REG) begin : g_chk
         assert_all_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((mask_w & SRC_FIELD) == SRC_FIELD) |-> !cascade_o)
            else $error("R5: cascade raised with every source masked");

         assert_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (src_lvl == '0) |-> !cascade_o)
            else $error("R7: cascade raised with no source active");
      end
   endgenerate

endmodule

// File: tb/irqagg_cascade_tb.sv
module irqagg_cascade_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  irq = '0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        casc;

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   irqagg_cascade u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .irq_i       (irq),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .cascade_o   (casc)
   );

   // vector: irq[3:0], mask bits 31..28, expected cascade
   localparam int NV = 9;
   localparam logic [8:0] VEC [NV] = '{
      {4'b0001, 4'b0000, 1'b1},
      {4'b0001, 4'b1000, 1'b0},
      {4'b0001, 4'b0001, 1'b1},
      {4'b1000, 4'b0001, 1'b0},
      {4'b1000, 4'b1110, 1'b1},
      {4'b0110, 4'b0110, 1'b0},
      {4'b0110, 4'b0100, 1'b1},
      {4'b1111, 4'b1111, 1'b0},
      {4'b0000, 4'b0000, 1'b0}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; addr = 4'h0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   function automatic logic [31:0] stat_of(input logic [3:0] v);
      logic [31:0] s = '0;
      for (int n = 0; n < 4; n++) s[31-n] = v[n];
      return s;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      irq = 4'hF;                       // lines high during reset
      repeat (4) @(negedge clk);
      chk({31'b0, casc}, 32'h0, "R9 cascade in reset");
      bus_read(4'h0, rd);
      chk(rd, 32'h0, "R9 status in reset");
      rst_n = 1'b1;
      irq = 4'h0;
      repeat (3) @(negedge clk);
      bus_read(4'h4, rd);
      chk(rd, 32'hFFF0_0000, "R3 mask reset value");
      chk({31'b0, casc}, 32'h0, "R3 cascade blocked after reset");

      // table walk: R1 R2 R5
      for (int i = 0; i < NV; i++) begin
         bus_write(4'h4, {VEC[i][4:1], 28'h0});
         @(negedge clk);
         irq = VEC[i][8:5];
         repeat (3) @(negedge clk);
         chk({31'b0, casc}, {31'b0, VEC[i][0]}, "R5 cascade vs mask");
         bus_read(4'h0, rd);
         chk(rd, stat_of(VEC[i][8:5]), "R1/R2 status placement");
      end

      // R4 full read-back
      bus_write(4'h4, 32'hA5C3_3C5A);
      bus_read(4'h4, rd);
      chk(rd, 32'hA5C3_3C5A, "R4 mask readback");

      // R6 low mask bits inert
      bus_write(4'h4, 32'h000F_FFFF);
      irq = 4'b0100;
      repeat (3) @(negedge clk);
      chk({31'b0, casc}, 32'h1, "R6 low mask bits ignored");

      // R7 level hold, write to status ignored, fall on drop
      bus_write(4'h0, 32'hFFFF_FFFF);
      chk({31'b0, casc}, 32'h1, "R7 still asserted");
      bus_read(4'h0, rd);
      chk(rd, stat_of(4'b0100), "R7 status unchanged by write");
      bus_read(4'h4, rd);
      chk(rd, 32'h000F_FFFF, "R7 mask unchanged by status write");
      irq = 4'b0000;
      repeat (3) @(negedge clk);
      chk({31'b0, casc}, 32'h0, "R7 falls when source drops");

      // R8 unmapped offset
      bus_write(4'h8, 32'hFFFF_FFFF);
      bus_read(4'h8, rd);
      chk(rd, 32'h0, "R8 unmapped read");
      bus_read(4'h4, rd);
      chk(rd, 32'h000F_FFFF, "R8 mask unchanged by unmapped write");

      // R1 latency: input changed at negedge, visible after 2nd posedge
      bus_write(4'h4, 32'h0);
      @(negedge clk);
      irq = 4'b0010;
      @(negedge clk);
      chk({31'b0, casc}, 32'h0, "R1 not visible after one edge");
      @(negedge clk);
      chk({31'b0, casc}, 32'h1, "R1 visible after two edges");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule